// File: doc/BRIEF.md
# Add/Subtract Unit with Status Flags

This block adds or subtracts two operands and reports six condition bits about the result: zero, sign, carry, signed overflow, nibble carry and parity. Subtraction is done by inverting the second operand and injecting a carry of one into the adder. All flags are taken from that single addition. The carry flag on a subtraction is therefore the raw carry-out of the addition, not a borrow: it is 1 when the first operand is unsigned greater than or equal to the second.

The result and the live flags come out combinationally. The flags are also captured into a holding register on a capture strobe. A parameter can remove that register, in which case the held output follows the live flags. A select input chooses whether parity is reported in the even or the odd convention.

Top module: `alu_flag_gen`

## Requirements
- R1: `result` is `opnd_a + opnd_b` modulo 2^W when `sub_sel`=0, and `opnd_a + ~opnd_b + 1` modulo 2^W when `sub_sel`=1.
- R2: The zero flag (`flags[3]`) is 1 exactly when `result` is all zeros.
- R3: The sign flag (`flags[4]`) equals the most significant bit of `result`.
- R4: The carry flag (`flags[0]`) is the carry-out of the W-bit addition. On subtraction this is the carry of the complement-add, so it is 1 when `opnd_a` >= `opnd_b` unsigned, including when `opnd_b` is 0.
- R5: The overflow flag (`flags[5]`) is 1 exactly when the true signed sum or difference of the operands lies outside the W-bit two's-complement range.
- R6: The nibble-carry flag (`flags[2]`) is the carry from bit 3 into bit 4. On subtraction it is computed from the inverted second operand plus the injected one.
- R7: The parity flag (`flags[1]`) looks only at `result[7:0]`. With `odd_par`=0 it is 1 when that byte holds an even number of ones. With `odd_par`=1 the sense is inverted.
- R8: With the holding stage present, `held_flags` takes the value of `flags` at each rising clock edge where `cap_en`=1, and keeps its value at every other edge.
- R9: A synchronous active-high `rst` clears `held_flags` to 0, and reset takes priority over `cap_en`.
- R10: Worked cases in the even convention (flags shown as bits [5:0]):
  - 06h+54h gives 5Ah with flags 000010.
  - 2Fh+DEh gives 0Dh with flags 000101.
  - 3Ch−28h gives 14h with flags 000111.
  - 5Ah−7Fh gives DBh with flags 010010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the holding stage |
| rst | input | 1 | Synchronous active-high reset |
| opnd_a | input | W | First operand |
| opnd_b | input | W | Second operand |
| sub_sel | input | 1 | 0 selects add, 1 selects subtract |
| odd_par | input | 1 | 0 selects the even parity convention, 1 selects odd |
| cap_en | input | 1 | Capture strobe for the holding stage |
| result | output | W | Sum or difference |
| flags | output | 6 | Live flags: [0] carry, [1] parity, [2] nibble carry, [3] zero, [4] sign, [5] overflow |
| held_flags | output | 6 | Flags captured on the last strobe |

## Verification
On every clock, the assertions check the following:
- the zero and sign flags agree with the result;
- the carry flag agrees with an unsigned comparison of the result against the first operand;
- overflow only occurs when the effective operand signs match and the result sign differs;
- the holding register captures on the strobe, holds otherwise, and clears on reset.

Only the bench's exhaustive sweep shows that every operand pair, in both operations and both parity conventions, gives the correct value for each flag. That includes the nibble carry and the parity sense. The four worked cases are checked directly against their stated flag values.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;
  localparam int NFLAG  = 6;
  localparam int F_CRY  = 0;
  localparam int F_PAR  = 1;
  localparam int F_NIB  = 2;
  localparam int F_ZERO = 3;
  localparam int F_SIGN = 4;
  localparam int F_OVF  = 5;
  localparam int NIB_W  = 4;
  localparam int PAR_W  = 8;
endpackage

// File: rtl/fg_adder.sv
module fg_adder
  import alu_flag_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         c_out,
  output logic         c_msb,
  output logic         c_nib
);
  localparam int LOW_W = W - 1;

  logic [W-1:0]     b_eff;
  logic [W:0]       full;
  logic [LOW_W:0]   low;
  logic [NIB_W:0]   nib;

  always_comb begin
    b_eff = sub ? ~b : b;
    full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
    low   = {1'b0, a[LOW_W-1:0]} + {1'b0, b_eff[LOW_W-1:0]} + {{LOW_W{1'b0}}, sub};
    nib   = {1'b0, a[NIB_W-1:0]} + {1'b0, b_eff[NIB_W-1:0]} + {{NIB_W{1'b0}}, sub};
    sum   = full[W-1:0];
    c_out = full[W];
    c_msb = low[LOW_W];
    c_nib = nib[NIB_W];
  end
endmodule

// File: rtl/fg_flags.sv
module fg_flags
  import alu_flag_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]     sum,
  input  logic             c_out,
  input  logic             c_msb,
  input  logic             c_nib,
  input  logic             odd_par,
  output logic [NFLAG-1:0] flg
);
  always_comb begin
    flg         = '0;
    flg[F_CRY]  = c_out;
    flg[F_OVF]  = c_out ^ c_msb;
    flg[F_NIB]  = c_nib;
    flg[F_ZERO] = (sum == '0);
    flg[F_SIGN] = sum[W-1];
    flg[F_PAR]  = ~(^sum[PAR_W-1:0]) ^ odd_par;
  end
endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen
  import alu_flag_pkg::*;
#(
  parameter int W        = 8,
  parameter bit HOLD_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     opnd_a,
  input  logic [W-1:0]     opnd_b,
  input  logic             sub_sel,
  input  logic             odd_par,
  input  logic             cap_en,
  output logic [W-1:0]     result,
  output logic [NFLAG-1:0] flags,
  output logic [NFLAG-1:0] held_flags
);
  logic c_out, c_msb, c_nib;

  fg_adder #(.W(W)) u_add (
    .a(opnd_a), .b(opnd_b), .sub(sub_sel),
    .sum(result), .c_out(c_out), .c_msb(c_msb), .c_nib(c_nib)
  );

  fg_flags #(.W(W)) u_flg (
    .sum(result), .c_out(c_out), .c_msb(c_msb), .c_nib(c_nib),
    .odd_par(odd_par), .flg(flags)
  );

  generate
    if (HOLD_REG) begin : g_hold
      logic [NFLAG-1:0] hold_q;
      always_ff @(posedge clk) begin
        if (rst)         hold_q <= '0;
        else if (cap_en) hold_q <= flags;
      end
      assign held_flags = hold_q;

      assert_capture_R8: assert property (@(posedge clk) disable iff (rst)
        cap_en |=> held_flags == $past(flags));
      assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !cap_en |=> $stable(held_flags));
      assert_reset_R9: assert property (@(posedge clk)
        rst |=> held_flags == '0);
    end else begin : g_pass
      assign held_flags = flags;
    end
  endgenerate

  logic [W-1:0] b_view;
  assign b_view = sub_sel ? ~opnd_b : opnd_b;

  assert_zero_R2: assert property (@(posedge clk) disable iff (rst)
    flags[F_ZERO] == (result == '0));
  assert_sign_R3: assert property (@(posedge clk) disable iff (rst)
    flags[F_SIGN] == result[W-1]);
  assert_carry_add_R4: assert property (@(posedge clk) disable iff (rst)
    !sub_sel |-> (flags[F_CRY] == (result < opnd_a)));
  assert_carry_sub_R4: assert property (@(posedge clk) disable iff (rst)
    sub_sel |-> (flags[F_CRY] == (opnd_a >= opnd_b)));
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    flags[F_OVF] |-> ((opnd_a[W-1] == b_view[W-1]) && (result[W-1] != opnd_a[W-1])));
endmodule

// File: tb/tb_alu_flag_gen.sv
module tb_alu_flag_gen;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] opnd_a = '0, opnd_b = '0;
  logic         sub_sel = 1'b0, odd_par = 1'b0, cap_en = 1'b0;
  logic [W-1:0] result;
  logic [5:0]   flags, held_flags;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_flag_gen #(.W(W), .HOLD_REG(1'b1)) dut (
    .clk(clk), .rst(rst), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .sub_sel(sub_sel), .odd_par(odd_par), .cap_en(cap_en),
    .result(result), .flags(flags), .held_flags(held_flags)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int ref_flags(input int a, input int b, input bit sub, input bit odd,
                                   output int res);
    int t, sa, sb, sv, ones, f;
    int bx;
    bx = sub ? ((~b) & 255) : b;
    t  = a + bx + (sub ? 1 : 0);
    res = t & 255;
    sa = (a > 127) ? a - 256 : a;
    sb = (b > 127) ? b - 256 : b;
    sv = sub ? sa - sb : sa + sb;
    ones = 0;
    for (int k = 0; k < 8; k++) ones += (res >> k) & 1;
    f = 0;
    if (t > 255)                                         f |= 1;
    if (((ones % 2) == 0) != odd)                        f |= 2;
    if (((a & 15) + (bx & 15) + (sub ? 1 : 0)) > 15)     f |= 4;
    if (res == 0)                                        f |= 8;
    if (res > 127)                                       f |= 16;
    if (sv > 127 || sv < -128)                           f |= 32;
    return f;
  endfunction

  task automatic apply(input int a, input int b, input bit sub, input bit odd);
    opnd_a = a[W-1:0]; opnd_b = b[W-1:0]; sub_sel = sub; odd_par = odd;
  endtask

  task automatic known(input int a, input int b, input bit sub, input int er, input int ef);
    apply(a, b, sub, 1'b0);
    #1;
    chk(int'(result) == er, "R10 result", int'(result), er);
    chk(int'(flags) == ef, "R10 flags", int'(flags), ef);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int er, ef, fails_before;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    chk(held_flags == 6'd0, "R9 reset state", int'(held_flags), 0);

    known(8'h06, 8'h54, 1'b0, 8'h5A, 6'b000010);
    known(8'h2F, 8'hDE, 1'b0, 8'h0D, 6'b000101);
    known(8'h3C, 8'h28, 1'b1, 8'h14, 6'b000111);
    known(8'h5A, 8'h7F, 1'b1, 8'hDB, 6'b010010);

    // R4 subtracting zero yields raw carry 1
    apply(8'h00, 8'h00, 1'b1, 1'b0); #1;
    chk(flags[0] == 1'b1, "R4 sub zero carry", int'(flags[0]), 1);

    // Exhaustive sweep: R1 R2 R3 R4 R5 R6 R7
    for (int od = 0; od < 2; od++)
      for (int sb = 0; sb < 2; sb++) begin
        fails_before = failures;
        for (int a = 0; a < 256; a++)
          for (int b = 0; b < 256; b++) begin
            apply(a, b, sb[0], od[0]);
            #1;
            ef = ref_flags(a, b, sb[0], od[0], er);
            if (int'(result) != er) begin
              chk(1'b0, "R1 result", int'(result), er);
            end else if (int'(flags) != ef) begin
              chk(1'b0, "R2 R3 R4 R5 R6 R7 flags", int'(flags), ef);
            end
          end
        chk(failures == fails_before, "R1 R7 sweep block", failures - fails_before, 0);
      end

    // R8 capture and hold, R9 reset priority
    @(negedge clk);
    apply(8'h2F, 8'hDE, 1'b0, 1'b0); cap_en = 1'b1;
    @(negedge clk);
    chk(held_flags == 6'b000101, "R8 capture", int'(held_flags), 6'b000101);
    apply(8'h5A, 8'h7F, 1'b1, 1'b0); cap_en = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(held_flags == 6'b000101, "R8 hold", int'(held_flags), 6'b000101);
    cap_en = 1'b1;
    @(negedge clk);
    chk(held_flags == 6'b010010, "R8 recapture", int'(held_flags), 6'b010010);
    rst = 1'b1;
    @(negedge clk);
    chk(held_flags == 6'd0, "R9 reset over capture", int'(held_flags), 0);
    rst = 1'b0; cap_en = 1'b0;
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    done = 1'b1;
    $finish;
  end
endmodule